// File: doc/BRIEF.md
# Auxiliary UART Register Bank

This block is the software-visible face of a simplified auxiliary serial port. A 32-bit word-access register port lets a processor read received bytes, send bytes, set interrupt enables and poll status words. Received bytes arrive on a valid/ready byte stream and are held in a circular receive buffer. A write to the data register sends its low byte out at once on a transmit stream. The transmitter is never busy, so it always reports empty and idle.

A single level interrupt output is driven from a two-bit pending vector. The vector is recomputed every cycle from the enable bits and the receive-buffer fill level. Line, modem, scratch, baud and divisor functions are absent. Their offsets, and any undecoded offset, read as zero and ignore writes.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the receive buffer is empty, both interrupt enables are clear, `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R2: A write to offset 0x44 stores only bits 1:0 (bit 0 = receive enable, bit 1 = transmit enable). A read of 0x44 returns those two bits ORed with 0xC0.
- R3: The receive pending bit is set when the receive enable is set and the buffer is non-empty. The transmit pending bit is set whenever the transmit enable is set. `irq` is high when either pending bit is set, and offset 0x00 reads 1 exactly when `irq` is high.
- R4: Offset 0x48 reads 0xC0 plus 0x4 when the buffer holds data, otherwise plus 0x2, plus 0x1 when no interrupt is pending.
- R5: A write to 0x48 with bit 1 set empties the receive buffer. A write with bit 1 clear leaves the buffer unchanged.
- R6: Offset 0x54 reads 0x60, with bit 0 also set when the buffer is non-empty.
- R7: Offset 0x64 reads 0x30E when the buffer is empty. Otherwise it reads 0x30F with the fill count placed at bit 16 upward.
- R8: Offset 0x60 always reads 0x3 and offset 0x04 always reads 0x1.
- R9: A read of 0x40 returns the oldest byte in arrival order. When the buffer is non-empty, the read removes that byte and the read pointer wraps from the last slot to slot 0. A byte accepted in the same cycle as such a read is kept.
- R10: A read of 0x40 with the buffer empty returns the byte in the slot at the read pointer and changes neither the pointer nor the count.
- R11: `rx_ready` is low when the buffer holds DEPTH bytes. An offered byte is not taken while `rx_ready` is low. Each accepted byte goes to slot (read pointer + count) modulo DEPTH.
- R12: A write to 0x40 raises `tx_valid` in that same cycle, with `tx_data` equal to bits 7:0 of the write data.
- R13: Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any undecoded offset read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be accepted |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the register port carries at most one access per cycle. They also assume that a flush and a receive acceptance never land in the same cycle, which holds because `rx_ready` drops while a flush write is on the port. Each stimulus step drives a single access or a single offered byte, or one data read together with one offered byte, always between clock edges. The bench reads data slots only after they have been filled, so the no-reset buffer storage is never observed before it is written.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SUMMARY = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ENABLES = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA    = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_IEN     = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_IID     = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_LSTAT   = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_XSTAT   = 8'h64;

  localparam logic [WORD_W-1:0] FIFO_EN_BITS = 32'h0000_00C0;
  localparam logic [WORD_W-1:0] LSTAT_IDLE   = 32'h0000_0060;
  localparam logic [WORD_W-1:0] XSTAT_IDLE   = 32'h0000_030E;
  localparam logic [WORD_W-1:0] CTRL_VALUE   = 32'h0000_0003;
  localparam int XSTAT_FILL_LSB = 16;

  typedef struct packed {
    logic tx;
    logic rx;
  } irq_vec_t;

  typedef struct packed {
    logic pop;
    logic tx_fire;
    logic ien_we;
    logic flush;
  } bus_ev_t;
endpackage

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [SUM_W-1:0]  slot_sum;
  logic [PTR_W-1:0]  wslot;
  logic              push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && (cnt_q != '0);

  // Slot for an incoming byte: read pointer plus fill, folded once.
  always_comb begin
    slot_sum = SUM_W'(rptr_q) + SUM_W'(cnt_q);
    if (slot_sum >= SUM_W'(DEPTH)) slot_sum = slot_sum - SUM_W'(DEPTH);
    wslot = slot_sum[PTR_W-1:0];
  end

  always_comb begin
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      cnt_d = '0;
    end else begin
      if (pop_ok) begin
        rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage carries no reset; the write is qualified by the push enable.
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wslot] <= data_i;
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/mu_irq_gen.sv
module mu_irq_gen
  import mu_pkg::*;
(
  input  logic [1:0] ien_i,
  input  logic       rx_nonempty_i,
  output irq_vec_t   pend_o,
  output logic       irq_o
);
  always_comb begin
    pend_o.rx = ien_i[0] && rx_nonempty_i;
    pend_o.tx = ien_i[1];
    irq_o     = pend_o.rx || pend_o.tx;
  end
endmodule

// File: rtl/mu_bus_decode.sv
module mu_bus_decode
  import mu_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flush_bit_i,
  output bus_ev_t           ev_o
);
  logic rd, wr;

  assign rd = valid_i && !write_i;
  assign wr = valid_i && write_i;

  always_comb begin
    ev_o.pop     = rd && (addr_i == OFF_DATA);
    ev_o.tx_fire = wr && (addr_i == OFF_DATA);
    ev_o.ien_we  = wr && (addr_i == OFF_IEN);
    ev_o.flush   = wr && (addr_i == OFF_IID) && flush_bit_i;
  end
endmodule

// File: rtl/mu_read_mux.sv
module mu_read_mux
  import mu_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        ien_i,
  input  irq_vec_t          pend_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic nonempty, any_pend;

  assign nonempty = (count_i != '0);
  assign any_pend = pend_i.rx || pend_i.tx;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_SUMMARY: rdata_o = WORD_W'(any_pend);
      OFF_ENABLES: rdata_o = WORD_W'(1);
      OFF_DATA:    rdata_o = WORD_W'(head_i);
      OFF_IEN:     rdata_o = FIFO_EN_BITS | WORD_W'(ien_i);
      OFF_IID:     rdata_o = FIFO_EN_BITS
                           | (nonempty ? WORD_W'(4) : WORD_W'(2))
                           | WORD_W'(!any_pend);
      OFF_LSTAT:   rdata_o = LSTAT_IDLE | WORD_W'(nonempty);
      OFF_CTRL:    rdata_o = CTRL_VALUE;
      OFF_XSTAT:   rdata_o = nonempty
                           ? (XSTAT_IDLE | WORD_W'(1)
                              | (WORD_W'(count_i) << XSTAT_FILL_LSB))
                           : XSTAT_IDLE;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
  import mu_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  bus_ev_t           ev;
  irq_vec_t          pend;
  logic [1:0]        ien_q, ien_d;
  logic [CNT_W-1:0]  rx_cnt;
  logic [DATA_W-1:0] rx_head;
  logic              rx_full;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:DATA_W]};

  mu_bus_decode u_dec (
    .valid_i     (bus_valid),
    .write_i     (bus_write),
    .addr_i      (bus_addr),
    .flush_bit_i (bus_wdata[1]),
    .ev_o        (ev)
  );

  // Interrupt-enable register: next state and storage kept apart.
  always_comb begin
    ien_d = ien_q;
    if (ev.ien_we) ien_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  assign rx_ready = !rx_full && !ev.flush;

  mu_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_valid && rx_ready),
    .data_i  (rx_data),
    .pop_i   (ev.pop),
    .flush_i (ev.flush),
    .head_o  (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full)
  );

  mu_irq_gen u_irq (
    .ien_i         (ien_q),
    .rx_nonempty_i (rx_cnt != '0),
    .pend_o        (pend),
    .irq_o         (irq)
  );

  mu_read_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rmux (
    .addr_i  (bus_addr),
    .head_i  (rx_head),
    .count_i (rx_cnt),
    .ien_i   (ien_q),
    .pend_i  (pend),
    .rdata_o (bus_rdata)
  );

  assign tx_valid = ev.tx_fire;
  assign tx_data  = bus_wdata[DATA_W-1:0];
endmodule

// File: rtl/mu_regs_chk.sv
module mu_regs_chk
  import mu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       ien
);
  logic rd_data, wr_data, flush_wr, accept;
  logic unused_chk;

  assign unused_chk = ^{bus_wdata[31:2], bus_wdata[0]};
  assign rd_data  = bus_valid && !bus_write && (bus_addr == OFF_DATA);
  assign wr_data  = bus_valid && bus_write && (bus_addr == OFF_DATA);
  assign flush_wr = bus_valid && bus_write && (bus_addr == OFF_IID) && bus_wdata[1];
  assign accept   = rx_valid && rx_ready;

  always_comb begin
    if (rst_n) a_r11_no_overflow: assert (count <= CNT_W'(DEPTH));
  end

  a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !rx_ready);

  a_r9_pop_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && count != '0 && !accept) |=> (count == $past(count) - 1'b1));

  a_r10_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && count == '0 && !accept) |=> (count == '0));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> (count == '0));

  a_r3_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ien[1] |-> irq);

  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien[1] || (ien[0] && count != '0)));

  a_r12_tx_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> wr_data);
endmodule

bind mini_uart_regs mu_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .count     (rx_cnt),
  .ien       (ien_q)
);

// File: tb/sim_mini_uart_regs.sv
module sim_mini_uart_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] s_rd;
  logic        s_txv, s_rdy, s_irq;
  logic [7:0]  s_txd;

  always #10 clk = ~clk;

  mini_uart_regs u0 (.*);

  localparam logic [3:0] OP_RD = 4'd0, OP_WR = 4'd1, OP_PUSH = 4'd2;
  localparam int NV = 34;
  // {requirement, op, offset, write data or expected read}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2,  OP_RD,   8'h44, 32'h0C0},   // R2 reset enables
    {4'd4,  OP_RD,   8'h48, 32'h0C3},   // R4 empty, none pending
    {4'd6,  OP_RD,   8'h54, 32'h060},   // R6
    {4'd7,  OP_RD,   8'h64, 32'h30E},   // R7
    {4'd3,  OP_RD,   8'h00, 32'h000},   // R3
    {4'd2,  OP_WR,   8'h44, 32'h0FF},   // R2 upper bits dropped
    {4'd2,  OP_RD,   8'h44, 32'h0C3},
    {4'd3,  OP_RD,   8'h00, 32'h001},   // R3 transmit pending
    {4'd4,  OP_RD,   8'h48, 32'h0C2},
    {4'd2,  OP_WR,   8'h44, 32'h001},
    {4'd3,  OP_RD,   8'h00, 32'h000},
    {4'd11, OP_PUSH, 8'h00, 32'h011},   // R11
    {4'd11, OP_PUSH, 8'h00, 32'h022},
    {4'd11, OP_PUSH, 8'h00, 32'h033},
    {4'd3,  OP_RD,   8'h00, 32'h001},   // R3 receive pending
    {4'd4,  OP_RD,   8'h48, 32'h0C4},
    {4'd6,  OP_RD,   8'h54, 32'h061},
    {4'd7,  OP_RD,   8'h64, 32'h0003030F},
    {4'd9,  OP_RD,   8'h40, 32'h011},   // R9
    {4'd7,  OP_RD,   8'h64, 32'h0002030F},
    {4'd5,  OP_WR,   8'h48, 32'h001},   // R5 no flush
    {4'd5,  OP_RD,   8'h54, 32'h061},
    {4'd5,  OP_WR,   8'h48, 32'h002},   // R5 flush
    {4'd5,  OP_RD,   8'h54, 32'h060},
    {4'd3,  OP_RD,   8'h00, 32'h000},
    {4'd8,  OP_RD,   8'h60, 32'h003},   // R8
    {4'd8,  OP_RD,   8'h04, 32'h001},
    {4'd13, OP_WR,   8'h5C, 32'h0AA},   // R13
    {4'd13, OP_RD,   8'h5C, 32'h000},
    {4'd13, OP_RD,   8'h4C, 32'h000},
    {4'd13, OP_RD,   8'h68, 32'h000},
    {4'd13, OP_RD,   8'h80, 32'h000},
    {4'd4,  OP_WR,   8'h44, 32'h000},
    {4'd4,  OP_RD,   8'h48, 32'h0C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive between edges, sample before the next rising edge.
  task automatic step(input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input bit rv, input logic [7:0] rd);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rd;
    #2;
    s_rd = bus_rdata; s_txv = tx_valid; s_txd = tx_data;
    s_rdy = rx_ready; s_irq = irq;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    step(1, 0, a, '0, 0, '0);
    chk(req, s_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 rx_ready", 32'(rx_ready), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [3:0] op; logic [7:0] a; logic [31:0] val;
      {rq, op, a, val} = VEC[i];
      if (op == OP_RD) begin
        step(1, 0, a, '0, 0, '0);
        chk($sformatf("R%0d row %0d", rq, i), s_rd, val);
      end else if (op == OP_WR) begin
        step(1, 1, a, val, 0, '0);
      end else begin
        step(0, 0, '0, '0, 1, val[7:0]);
      end
    end

    // R11: fill to DEPTH with the write slot wrapping (read pointer is 1).
    for (int i = 0; i < 8; i++) begin
      step(0, 0, '0, '0, 1, 8'hA0 + 8'(i));
      chk("R11 ready while filling", 32'(s_rdy), 32'd1);
    end
    step(0, 0, '0, '0, 1, 8'hEE);
    chk("R11 ready low when full", 32'(s_rdy), 32'd0);
    rd_chk("R11 fill count", 8'h64, 32'h0008030F);
    // R9: drain in arrival order across the wrap.
    for (int i = 0; i < 8; i++) rd_chk("R9 order", 8'h40, 32'hA0 + 32'(i));
    // R10: empty read returns stale slot and leaves state.
    rd_chk("R10 stale byte", 8'h40, 32'h0A0);
    rd_chk("R10 still empty", 8'h64, 32'h30E);

    // R9: pop and accept in one cycle.
    step(0, 0, '0, '0, 1, 8'h01);
    step(1, 0, 8'h40, '0, 1, 8'h02);
    chk("R9 concurrent pop", s_rd, 32'h001);
    rd_chk("R9 concurrent count", 8'h64, 32'h0001030F);
    rd_chk("R9 concurrent keep", 8'h40, 32'h002);

    // R12: transmit strobe.
    step(1, 1, 8'h40, 32'h0000_015A, 0, '0);
    chk("R12 tx_valid", 32'(s_txv), 32'd1);
    chk("R12 tx_data", 32'(s_txd), 32'h5A);
    step(1, 0, 8'h44, '0, 0, '0);
    chk("R12 no strobe on read", 32'(s_txv), 32'd0);

    // R1: reset mid-run clears enables and buffer.
    step(0, 0, '0, '0, 1, 8'h77);
    step(1, 1, 8'h44, 32'h3, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R1 irq in reset", 32'(irq), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 buffer empty", 8'h64, 32'h30E);
    rd_chk("R1 enables clear", 8'h44, 32'h0C0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule